// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number plus an offset, into a physical address. It keeps a small segment table in internal registers. Each row holds a starting physical address, a segment length, a valid flag and three permission flags for reading, writing and instruction fetch. A separate count register sets how many segments are currently legal. Software-side logic fills the table through a plain write port and sets the count through a second write port.

Each request carries a segment number, an offset and an access kind. It enters through a valid/ready handshake, and exactly one response leaves through a second valid/ready handshake on the following cycle. The checks are staged, and the first stage that fails decides the fault code. A successful response carries base plus offset. A faulting response carries one of four codes and a zero address.

A new request is accepted only when the single response slot is empty or is being drained in the same cycle. While the response is stalled by a low `rsp_ready`, the response is held and `req_ready` stays low.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, every table row is invalid and the segment count is 0, so any lookup faults with code 0.
- R2: Writing the segment count with a value above the table depth N stores N.
- R3: A segment number greater than or equal to the stored count faults with code 0 (out of range).
- R4: A segment in range whose valid flag is 0 faults with code 1 (invalid entry).
- R5: An offset that is not strictly less than the row's length faults with code 2 (beyond limit).
- R6: Permission flags are perm[0]=read, perm[1]=write, perm[2]=fetch. Access kind 0 (read) needs perm[0], kind 1 (write) needs perm[1] and kind 2 (fetch) needs perm[2]. Kind 3 always faults. Each failure gives code 3.
- R7: When several checks fail, the lowest code among R3, R4, R5 and R6 is reported.
- R8: With no fault, `rsp_fault` is 0 and `rsp_paddr` is the zero-extended sum base + offset, one bit wider than the base so no carry is lost. With a fault, `rsp_paddr` is 0.
- R9: A table write and a lookup of the same row in the same cycle give a result from the row's old contents. Later lookups see the new contents.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response outputs stay unchanged and `req_ready` is 0.
- R11: Each accepted request yields exactly one response, in order, with `rsp_valid` rising on the clock edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table row write enable |
| tbl_idx | input | 3 | Row to write |
| tbl_base | input | 16 | New row base |
| tbl_limit | input | 16 | New row length |
| tbl_valid | input | 1 | New row valid flag |
| tbl_perm | input | 3 | New row permissions {fetch, write, read} |
| cnt_we | input | 1 | Segment count write enable |
| cnt_val | input | 4 | New segment count (saturated to N) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset in segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 2 | Fault code 0..3 (0 when no fault) |
| rsp_paddr | output | 17 | Physical address, 0 on fault |

## Verification
The bench builds the block with its defaults: eight rows, 16-bit base and length, and a 4-bit segment number. The segment number is one bit wider than a row index, so numbers 8 to 15 lie past any possible count, and a count write of 12 exercises saturation. With the 16-bit fields, a base near the top plus a large offset reaches the carry bit of the 17-bit address. A zero-length row makes every offset a limit fault.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_RANGE   = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_LIMIT   = 2'd2,
    FLT_PERM    = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_BITS = 3;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [AW-1:0]        wr_base,
  input  logic [AW-1:0]        wr_limit,
  input  logic                 wr_valid,
  input  logic [PERM_BITS-1:0] wr_perm,
  input  logic [IW-1:0]        rd_idx,
  output logic [AW-1:0]        rd_base,
  output logic [AW-1:0]        rd_limit,
  output logic                 rd_valid,
  output logic [PERM_BITS-1:0] rd_perm
);
  logic [AW-1:0]        base_q  [N];
  logic [AW-1:0]        limit_q [N];
  logic                 valid_q [N];
  logic [PERM_BITS-1:0] perm_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        valid_q[g] <= 1'b0;
        perm_q[g]  <= '0;
      end else if (wr_en && int'(wr_idx) == g) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        valid_q[g] <= wr_valid;
        perm_q[g]  <= wr_perm;
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    rd_valid = 1'b0;
    rd_perm  = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(rd_idx) == i) begin
        rd_base  = base_q[i];
        rd_limit = limit_q[i];
        rd_valid = valid_q[i];
        rd_perm  = perm_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SEG_W = 4,
  parameter int LW    = 4
) (
  input  logic [SEG_W-1:0]     seg,
  input  logic [LW-1:0]        count,
  input  logic [AW-1:0]        off,
  input  logic [1:0]           acc,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        limit,
  input  logic                 valid,
  input  logic [PERM_BITS-1:0] perm,
  output logic                 fault,
  output flt_e                 code,
  output logic [AW:0]          paddr
);
  logic allowed;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  allowed = perm[0];
      ACC_WRITE: allowed = perm[1];
      ACC_FETCH: allowed = perm[2];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    fault = 1'b1;
    paddr = '0;
    if (int'(seg) >= int'(count)) begin
      code = FLT_RANGE;
    end else if (!valid) begin
      code = FLT_INVALID;
    end else if (off >= limit) begin
      code = FLT_LIMIT;
    end else if (!allowed) begin
      code = FLT_PERM;
    end else begin
      code  = FLT_RANGE;
      fault = 1'b0;
      paddr = {1'b0, base} + {1'b0, off};
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 16,
  parameter int SEG_W = 4,
  localparam int IW   = $clog2(N),
  localparam int LW   = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic [IW-1:0]        tbl_idx,
  input  logic [AW-1:0]        tbl_base,
  input  logic [AW-1:0]        tbl_limit,
  input  logic                 tbl_valid,
  input  logic [PERM_BITS-1:0] tbl_perm,
  input  logic                 cnt_we,
  input  logic [LW-1:0]        cnt_val,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEG_W-1:0]     req_seg,
  input  logic [AW-1:0]        req_off,
  input  logic [1:0]           req_acc,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_fault,
  output logic [1:0]           rsp_code,
  output logic [AW:0]          rsp_paddr
);
  logic [LW-1:0]        len_q;
  logic [AW-1:0]        e_base, e_limit;
  logic                 e_valid;
  logic [PERM_BITS-1:0] e_perm;
  logic                 c_fault;
  flt_e                 c_code;
  logic [AW:0]          c_paddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (cnt_we) begin
      len_q <= (int'(cnt_val) > N) ? LW'(N) : cnt_val;
    end
  end

  seg_table #(.N(N), .AW(AW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_base  (tbl_base),
    .wr_limit (tbl_limit),
    .wr_valid (tbl_valid),
    .wr_perm  (tbl_perm),
    .rd_idx   (req_seg[IW-1:0]),
    .rd_base  (e_base),
    .rd_limit (e_limit),
    .rd_valid (e_valid),
    .rd_perm  (e_perm)
  );

  seg_check #(.AW(AW), .SEG_W(SEG_W), .LW(LW)) u_check (
    .seg   (req_seg),
    .count (len_q),
    .off   (req_off),
    .acc   (req_acc),
    .base  (e_base),
    .limit (e_limit),
    .valid (e_valid),
    .perm  (e_perm),
    .fault (c_fault),
    .code  (c_code),
    .paddr (c_paddr)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
      rsp_paddr <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= c_fault;
        rsp_code  <= c_code;
        rsp_paddr <= c_paddr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int N     = 8,
  parameter int SEG_W = 4,
  parameter int LW    = 4,
  parameter int PW    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic [LW-1:0]    len_q,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [1:0]       rsp_code,
  input logic [PW-1:0]    rsp_paddr
);
  a_r2_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len_q) <= N);

  a_r3_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && int'(req_seg) >= int'(len_q))
      |=> (rsp_valid && rsp_fault && rsp_code == 2'd0));

  a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready)
      |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_code) && $stable(rsp_paddr)));

  a_r10_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

bind seg_xlate seg_xlate_chk #(.N(N), .SEG_W(SEG_W), .LW(LW), .PW(AW + 1)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_seg   (req_seg),
  .len_q     (len_q),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_fault (rsp_fault),
  .rsp_code  (rsp_code),
  .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [15:0] tbl_base = '0, tbl_limit = '0;
  logic        tbl_valid = 1'b0;
  logic [2:0]  tbl_perm = '0;
  logic        cnt_we = 1'b0;
  logic [3:0]  cnt_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [1:0]  rsp_code;
  logic [16:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  int n_req = 0;
  int n_rsp = 0;

  typedef struct packed {
    logic        fault;
    logic [1:0]  code;
    logic [16:0] paddr;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] m_base [N];
  logic [15:0] m_limit[N];
  logic        m_valid[N];
  logic [2:0]  m_perm [N];
  int          m_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .tbl_valid(tbl_valid), .tbl_perm(tbl_perm),
    .cnt_we(cnt_we), .cnt_val(cnt_val),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference from R3..R8
  function automatic exp_t model(int seg, logic [15:0] off, logic [1:0] acc);
    exp_t e;
    logic ok;
    e = '{fault: 1'b1, code: 2'd0, paddr: '0};
    if (seg >= m_cnt) e.code = 2'd0;
    else if (!m_valid[seg]) e.code = 2'd1;
    else if (off >= m_limit[seg]) e.code = 2'd2;
    else begin
      ok = (acc == 2'd0) ? m_perm[seg][0] :
           (acc == 2'd1) ? m_perm[seg][1] :
           (acc == 2'd2) ? m_perm[seg][2] : 1'b0;
      if (!ok) e.code = 2'd3;
      else begin
        e.fault = 1'b0;
        e.paddr = {1'b0, m_base[seg]} + {1'b0, off};
      end
    end
    return e;
  endfunction

  // Driver: optional table write in the same cycle as an optional request
  task automatic xfer(bit do_wr, int idx, logic [15:0] b, logic [15:0] l, logic v,
                      logic [2:0] p, bit do_req, int seg, logic [15:0] off, logic [1:0] acc);
    @(negedge clk);
    if (do_req) begin
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_seg = 4'(seg);
      req_off = off;
      req_acc = acc;
      exp_q.push_back(model(seg, off, acc));
      n_req++;
    end
    if (do_wr) begin
      tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_base = b; tbl_limit = l;
      tbl_valid = v; tbl_perm = p;
    end
    @(posedge clk);
    if (do_wr) begin
      m_base[idx] = b; m_limit[idx] = l; m_valid[idx] = v; m_perm[idx] = p;
    end
    @(negedge clk);
    req_valid = 1'b0;
    tbl_we = 1'b0;
  endtask

  task automatic wr_row(int idx, logic [15:0] b, logic [15:0] l, logic v, logic [2:0] p);
    xfer(1'b1, idx, b, l, v, p, 1'b0, 0, '0, '0);
  endtask

  task automatic look(int seg, logic [15:0] off, logic [1:0] acc);
    xfer(1'b0, 0, '0, '0, 1'b0, '0, 1'b1, seg, off, acc);
  endtask

  task automatic wr_cnt(int v);
    @(negedge clk);
    cnt_we = 1'b1;
    cnt_val = 4'(v);
    @(posedge clk);
    m_cnt = (v > N) ? N : v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // Monitor: compare each consumed response, and track stalled holds (R10)
  exp_t held;
  bit   hold_pend = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check("R10 held response", {rsp_valid, rsp_fault, rsp_code, rsp_paddr},
              {1'b1, held.fault, held.code, held.paddr});
        check("R10 req_ready low while stalled", 32'(req_ready), 32'(rsp_ready));
      end
      hold_pend = rsp_valid && !rsp_ready;
      held = '{fault: rsp_fault, code: rsp_code, paddr: rsp_paddr};
      if (rsp_valid && rsp_ready) begin
        n_rsp++;
        if (exp_q.size() == 0) begin
          check("R11 unexpected response", 32'(rsp_valid), 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R3-R9 fault", 32'(rsp_fault), 32'(e.fault));
          check("R7 code", 32'(rsp_code), 32'(e.code));
          check("R8 paddr", 32'(rsp_paddr), 32'(e.paddr));
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0; m_perm[i] = '0;
    end
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 req_ready after reset", 32'(req_ready), 32'd1);
    look(0, 16'h0, 2'd0);                       // R1, R3: count 0
    wr_row(0, 16'h1000, 16'h0100, 1'b1, 3'b001);
    wr_row(1, 16'hF000, 16'h2000, 1'b1, 3'b111);
    wr_row(2, 16'h3000, 16'h0100, 1'b0, 3'b111);
    wr_row(3, 16'h0200, 16'h0000, 1'b1, 3'b011);
    wr_row(5, 16'h4000, 16'h0010, 1'b1, 3'b100);
    wr_cnt(3);
    look(3, 16'h0, 2'd0);                       // R3: valid row past count
    look(2, 16'h0, 2'd0);                       // R4
    wr_cnt(12);                                 // R2: saturates to 8
    look(7, 16'h0, 2'd0);                       // R2: in range, invalid -> code 1
    look(8, 16'h0, 2'd0);                       // R2/R3: seg 8 out of range
    look(9, 16'h0, 2'd1);                       // R3
    look(0, 16'h00FF, 2'd0);                    // R8 ok
    look(0, 16'h0100, 2'd0);                    // R5 offset == limit
    look(0, 16'h0010, 2'd1);                    // R6 write denied
    look(0, 16'h0010, 2'd3);                    // R6 reserved kind
    look(1, 16'h1FFF, 2'd2);                    // R8 carry bit
    look(5, 16'h000F, 2'd2);                    // R6 fetch ok
    look(5, 16'h0001, 2'd0);                    // R6 read denied
    look(2, 16'hFFFF, 2'd3);                    // R7 invalid beats limit/perm
    look(3, 16'h0005, 2'd2);                    // R7 limit beats perm
    look(15, 16'hFFFF, 2'd3);                   // R7 range beats all
    xfer(1'b1, 6, 16'h5000, 16'h0040, 1'b1, 3'b001, 1'b1, 6, 16'h0004, 2'd0); // R9 old
    look(6, 16'h0004, 2'd0);                    // R9 new
    // R10: stall the consumer
    @(negedge clk);
    rsp_ready = 1'b0;
    look(1, 16'h0042, 2'd1);
    repeat (3) @(negedge clk);
    check("R10 req_ready while stalled", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    // back-to-back requests (R11)
    look(0, 16'h0001, 2'd0);
    look(1, 16'h0002, 2'd1);
    repeat (3) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 32'd0);
    check("R11 response count", 32'(n_rsp), 32'(n_req));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule